// File: doc/BRIEF.md
# Barrel Thread Issue Selector

This block decides, on every clock cycle, which of several hardware thread contexts may place one instruction into a shared pipeline. It keeps two flags per context. The in-flight flag marks a thread that already has an instruction in the pipeline. The blocked flag marks a thread that is waiting for a long-latency memory reply. Only a thread with neither flag set is available. The block searches the available threads in rotating order and grants the slot to one of them. Each thread therefore has at most one instruction in flight, and the pipeline needs no dependency check or branch predictor within a thread.

The pipeline reports two kinds of event. It acknowledges the retirement of a thread's instruction, tagged with the thread number. It also marks a thread as waiting on memory, or releases that wait, through one bit per thread. When no thread is available, the block issues a bubble. The external reset is asynchronous and active low. Inside the block its release is synchronised over two clock edges.

Top module: `barrel_thread_sel`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `issue_valid` is 0. In the first cycle in which the block may issue, every thread is available and thread 0 is granted.
- R2: The search starts at the thread just above the last thread granted, rises in thread number, and wraps from NUM_THREADS-1 to 0. The first available thread found is granted, and `issue_tid` gives its number in binary.
- R3: A granted thread is in flight from the next cycle and is not granted again until `wb_ack_valid` is 1 with `wb_ack_tid` equal to its number. It becomes available in the cycle after that acknowledge. An acknowledge in the same cycle as the grant does not clear the flag.
- R4: Bit i of `mem_wait_set` at 1 blocks thread i from the next cycle on. Bit i of `mem_wait_clr` at 1 unblocks it from the next cycle on. When both bits are 1 together, the thread ends up blocked.
- R5: When no thread is available, `issue_valid` is 0, `issue_tid` is 0, and the rotation point stays where the last grant left it.
- R6: When all threads are available and each grant is acknowledged in the following cycle, every thread is granted exactly once in every NUM_THREADS cycles.
- R7: No thread is granted in two consecutive cycles.
- R8: An acknowledge for a thread that is not in flight changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two synchronising flops |
| mem_wait_set | input | NUM_THREADS | Per-thread mark: the thread is waiting on memory |
| mem_wait_clr | input | NUM_THREADS | Per-thread release of the memory wait |
| wb_ack_valid | input | 1 | A thread's in-flight instruction retired this cycle |
| wb_ack_tid | input | TID_W | Thread number of the retiring instruction |
| issue_valid | output | 1 | An issue slot is granted this cycle |
| issue_tid | output | TID_W | Thread granted this cycle; 0 when no slot is granted |

## Verification
The bench builds the block with five threads and a three-bit thread number. A count that is not a power of two exercises the wrap from thread 4 to thread 0 without relying on counter overflow, and it leaves three unused thread codes that must never appear. Five threads are few enough that the bench can put every thread in flight, or blocked, at once. This brings within reach the bubble case, the resumption of rotation after an idle stretch, and the situations where memory waits and acknowledges interact on the same thread.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  // Per-context status flags
  typedef struct packed {
    logic inflight;
    logic blocked;
  } ctx_stat_t;

  // Index reached by stepping forward on a ring of n slots
  function automatic int unsigned ring_next(int unsigned base,
                                            int unsigned step,
                                            int unsigned n);
    int unsigned sum;
    sum = base + step;
    if (sum >= n) sum = sum - n;
    return sum;
  endfunction

endpackage

// File: rtl/bsel_ctx_state.sv
module bsel_ctx_state
  import barrel_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic [TW-1:0] issue_tid,
  input  logic [N-1:0]  mem_set,
  input  logic [N-1:0]  mem_clr,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tid,
  output logic [N-1:0]  eligible
);

  logic [N-1:0] inflight_vec;
  logic [N-1:0] blocked_vec;

  for (genvar g = 0; g < N; g++) begin : g_ctx
    ctx_stat_t st_q;
    ctx_stat_t st_d;
    logic      st_en;

    always_comb begin
      st_d.inflight = (st_q.inflight && !(wb_valid && (wb_tid == TW'(g))))
                    || (issue_en && (issue_tid == TW'(g)));
      st_d.blocked  = mem_set[g] || (st_q.blocked && !mem_clr[g]);
      st_en         = (st_d != st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
      end else if (st_en) begin
        st_q <= st_d;
      end
    end

    assign inflight_vec[g] = st_q.inflight;
    assign blocked_vec[g]  = st_q.blocked;
    assign eligible[g]     = !st_q.inflight && !st_q.blocked;

    // R4
    wait_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_set[g] |=> blocked_vec[g]);
  end

  // R3
  grant_not_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !inflight_vec[issue_tid]);

  // R4
  grant_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !blocked_vec[issue_tid]);

  // R3
  grant_marks_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> inflight_vec[$past(issue_tid)]);

endmodule

// File: rtl/bsel_rr_pick.sv
module bsel_rr_pick
  import barrel_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned TW = 3
) (
  input  logic [N-1:0]  eligible,
  input  logic [TW-1:0] last_tid,
  output logic          pick_valid,
  output logic [TW-1:0] pick_tid
);

  int unsigned cand;

  always_comb begin
    pick_valid = 1'b0;
    pick_tid   = '0;
    cand       = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      cand = ring_next(int'(last_tid), k, N);
      if (!pick_valid && eligible[cand]) begin
        pick_valid = 1'b1;
        pick_tid   = TW'(cand);
      end
    end
  end

endmodule

// File: rtl/bsel_rotor.sv
module bsel_rotor #(
  parameter int unsigned N  = 8,
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_en,
  input  logic [TW-1:0] issue_tid,
  output logic [TW-1:0] last_tid
);

  logic [TW-1:0] last_q;
  logic [TW-1:0] last_d;
  logic          last_en;

  always_comb begin
    last_en = issue_en;
    last_d  = issue_tid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= TW'(N - 1);
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  assign last_tid = last_q;

  // R2
  rotor_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> (last_q == $past(issue_tid)));

  // R5
  rotor_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |=> $stable(last_q));

endmodule

// File: rtl/barrel_thread_sel.sv
module barrel_thread_sel #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] mem_wait_set,
  input  logic [NUM_THREADS-1:0] mem_wait_clr,
  input  logic                   wb_ack_valid,
  input  logic [TID_W-1:0]       wb_ack_tid,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid
);

  localparam int unsigned N  = NUM_THREADS;
  localparam int unsigned TW = TID_W;

  // Reset release synchroniser
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N-1:0]  eligible;
  logic [TW-1:0] last_tid;
  logic          pick_valid;
  logic [TW-1:0] pick_tid;
  logic          grant;

  assign grant       = pick_valid && rst_sync_q;
  assign issue_valid = grant;
  assign issue_tid   = grant ? pick_tid : '0;

  bsel_ctx_state #(.N(N), .TW(TW)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .issue_en  (grant),
    .issue_tid (pick_tid),
    .mem_set   (mem_wait_set),
    .mem_clr   (mem_wait_clr),
    .wb_valid  (wb_ack_valid),
    .wb_tid    (wb_ack_tid),
    .eligible  (eligible)
  );

  bsel_rr_pick #(.N(N), .TW(TW)) u_pick (
    .eligible   (eligible),
    .last_tid   (last_tid),
    .pick_valid (pick_valid),
    .pick_tid   (pick_tid)
  );

  bsel_rotor #(.N(N), .TW(TW)) u_rotor (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .issue_en  (grant),
    .issue_tid (pick_tid),
    .last_tid  (last_tid)
  );

  // R7
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (issue_valid && $past(issue_valid)) |-> (issue_tid != $past(issue_tid)));

  // R5
  bubble_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (eligible == '0) |-> (!issue_valid && (issue_tid == '0)));

  // R2
  tid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    issue_valid |-> (int'(issue_tid) < N));

endmodule

// File: tb/tb_barrel_thread_sel.sv
module tb_barrel_thread_sel;

  localparam int N          = 5;
  localparam int TW         = 3;
  localparam int CLK_PERIOD = 10;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  mem_wait_set;
  logic [N-1:0]  mem_wait_clr;
  logic          wb_ack_valid;
  logic [TW-1:0] wb_ack_tid;
  logic          issue_valid;
  logic [TW-1:0] issue_tid;

  barrel_thread_sel #(.NUM_THREADS(N), .TID_W(TW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_wait_set (mem_wait_set),
    .mem_wait_clr (mem_wait_clr),
    .wb_ack_valid (wb_ack_valid),
    .wb_ack_tid   (wb_ack_tid),
    .issue_valid  (issue_valid),
    .issue_tid    (issue_tid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit    v;
    int    t;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    vectors;
  int    miscompares;
  bit    done;

  // Reference model state
  bit    m_inf[N];
  bit    m_blk[N];
  int    m_last;
  bit    prev_v;
  int    prev_t;
  int    cyc;
  int    last_seen[N];

  task automatic predict(output bit v, output int t);
    v = 1'b0;
    t = 0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_last + k) % N;
      if (!v && !m_inf[idx] && !m_blk[idx]) begin
        v = 1'b1;
        t = idx;
      end
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected grant
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] c,
                      input bit wv, input int wt, input string req);
    bit ev;
    int et;
    @(negedge clk);
    mem_wait_set = s;
    mem_wait_clr = c;
    wb_ack_valid = wv;
    wb_ack_tid   = TW'(wt);
    predict(ev, et);
    sb_q.push_back('{ev, et, req});
    for (int i = 0; i < N; i++) begin
      m_inf[i] = (m_inf[i] && !(wv && wt == i)) || (ev && et == i);
      m_blk[i] = s[i] || (m_blk[i] && !c[i]);
    end
    if (ev) m_last = et;
    prev_v = ev;
    prev_t = et;
  endtask

  // Step that acknowledges the grant of the previous cycle
  task automatic auto_step(input logic [N-1:0] s, input logic [N-1:0] c,
                           input string req);
    step(s, c, prev_v, prev_t, req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        vectors++;
        cyc++;
        if (issue_valid !== e.v || (e.v && issue_tid !== TW'(e.t)) ||
            (!e.v && issue_tid !== '0)) begin
          miscompares++;
          $display("FAIL %s: valid/tid actual %0b/%0d expected %0b/%0d",
                   e.req, issue_valid, issue_tid, e.v, e.v ? e.t : 0);
        end
        if (issue_valid === 1'b1 && int'(issue_tid) < N) begin
          if (e.req == "R6") begin
            vectors++;
            if (cyc - last_seen[issue_tid] != N) begin
              miscompares++;
              $display("FAIL R6: thread %0d spacing actual %0d expected %0d",
                       issue_tid, cyc - last_seen[issue_tid], N);
            end
          end
          last_seen[issue_tid] = cyc;
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0; cyc = 0;
    for (int i = 0; i < N; i++) begin
      m_inf[i] = 1'b0; m_blk[i] = 1'b0; last_seen[i] = -100;
    end
    m_last = N - 1; prev_v = 1'b0; prev_t = 0;
    rst_n = 1'b0; mem_wait_set = '0; mem_wait_clr = '0;
    wb_ack_valid = 1'b0; wb_ack_tid = '0;

    // R1: quiet in reset and on the first edge after release
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (issue_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: valid in reset actual %0b expected 0", issue_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    vectors++;
    if (issue_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: valid after first edge actual %0b expected 0", issue_valid);
    end

    // R1 then R2: first grant is thread 0, then rotation with wrap
    auto_step('0, '0, "R1");
    repeat (6) auto_step('0, '0, "R2");

    // R6: steady rotation spacing
    repeat (10) auto_step('0, '0, "R6");

    // R4: block 2 and 3, release 2, set and clear together on 1
    auto_step(5'b01100, '0, "R4");
    repeat (5) auto_step('0, '0, "R4");
    auto_step('0, 5'b00100, "R4");
    repeat (4) auto_step('0, '0, "R4");
    auto_step(5'b00010, 5'b00010, "R4");
    repeat (5) auto_step('0, '0, "R4");
    auto_step('0, 5'b01010, "R4");
    repeat (4) auto_step('0, '0, "R4");

    // R3: stop acknowledging, all threads fill up
    repeat (6) step('0, '0, 1'b0, 0, "R3");
    // R5: bubbles
    repeat (3) step('0, '0, 1'b0, 0, "R5");
    step(5'b10001, '0, 1'b0, 0, "R5");
    step('0, '0, 1'b1, 0, "R5");
    step('0, '0, 1'b1, 4, "R5");
    step('0, '0, 1'b1, 3, "R3");
    step('0, '0, 1'b0, 0, "R3");
    // R5: release two at once, rotation resumes after last grant
    step('0, 5'b10001, 1'b0, 0, "R5");
    repeat (3) step('0, '0, 1'b0, 0, "R5");

    // R8: ack to a blocked idle thread does nothing
    step(5'b00100, '0, 1'b0, 0, "R8");
    step('0, '0, 1'b1, 2, "R8");
    step('0, '0, 1'b1, 2, "R8");
    step('0, '0, 1'b0, 0, "R8");
    step('0, 5'b00100, 1'b0, 0, "R8");
    // R3: ack in the same cycle as the grant does not clear
    step('0, '0, 1'b1, 2, "R3");
    step('0, '0, 1'b0, 0, "R3");
    step('0, '0, 1'b1, 2, "R3");
    step('0, '0, 1'b0, 0, "R3");

    // R7 with R2: drain and mixed rotation
    step('0, '0, 1'b1, 0, "R7");
    step('0, '0, 1'b1, 1, "R7");
    step('0, '0, 1'b1, 3, "R7");
    step('0, '0, 1'b1, 4, "R7");
    repeat (12) auto_step('0, '0, "R2");

    repeat (3) @(negedge clk);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule